// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine that paints into an 8-bit-per-pixel frame buffer held in an external synchronous RAM. One launch pulse starts a solid fill or a screen-to-screen copy. The command inputs are sampled on that pulse: operation type, raster operation, foreground color, source and destination base addresses, line stride, packed source and destination positions, and a packed rectangle size. The engine then walks the rectangle one pixel at a time on its memory port and reports through `busy_o` while it works.

A copy may have overlapping source and destination areas. The horizontal and vertical walk directions are chosen separately, so that no source pixel is overwritten before it has been read. When a direction runs backwards, the walk starts from the far end of that axis. A fill can write the color directly, or it can read each destination pixel and XOR the color into it, which inverts an area.

Positions are 12-bit. A requester whose position lies beyond that range adds the offset into the base address and passes coordinate 0.

Top module: `blit_rect_engine`

## Requirements
- R1: A `launch_i` pulse while idle with a non-zero size raises `busy_o` on the next cycle. `busy_o` falls in the cycle after the final pixel write. A COPY-rop fill is busy for exactly width×height cycles. An XOR fill or a copy is busy for exactly 2×width×height cycles.
- R2: `size_i` holds the width in bits 15:0 and the height in bits 31:16. Each XY input holds X in bits 11:0 and Y in bits 27:16. Bits 15:12 and 31:28 of an XY input are ignored.
- R3: A pixel at (X, Y) lives at byte address base + Y×stride + X, with one byte per pixel.
- R4: A fill with `rop_i`=0 (`cmd_i`=0) writes the color to every pixel of the rectangle, one write per cycle, and issues no reads.
- R5: A fill with `rop_i`=1 reads each destination pixel and, in the next cycle, writes that pixel XOR the color. Each pixel gets exactly one read and one write.
- R6: A copy (`cmd_i`=1) reads a source pixel and, in the next cycle, writes that value unchanged to the matching destination pixel. `rop_i` has no effect on a copy.
- R7: For a copy, if source X ≤ destination X, each row is walked from column width−1 down to 0. Otherwise each row is walked from 0 up to width−1.
- R8: For a copy, if source Y ≤ destination Y, rows are walked from row height−1 up to row 0. Otherwise rows are walked from 0 down to height−1. An overlapping copy therefore leaves the destination equal to the source as it was before the copy.
- R9: A fill always walks left to right within a row and top to bottom across rows.
- R10: A launch with a width or a height of zero leaves `busy_o` low and makes no memory access.
- R11: A `launch_i` pulse while busy is ignored; the running operation finishes unchanged.
- R12: Read data is taken one cycle after `mem_re_o`. `mem_re_o` and `mem_we_o` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start pulse |
| cmd_i | input | 1 | 0 fill, 1 copy |
| rop_i | input | 1 | Fill raster op: 0 set color, 1 XOR color |
| color_i | input | 8 | Foreground color |
| src_base_i | input | AW | Source base byte address |
| dst_base_i | input | AW | Destination base byte address |
| stride_i | input | STRIDE_W | Bytes per line |
| src_xy_i | input | 32 | Packed source position |
| dst_xy_i | input | 32 | Packed destination position |
| size_i | input | 32 | Packed width and height |
| busy_o | output | 1 | Operation in progress |
| mem_addr_o | output | AW | Memory byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the read |

## Verification
`busy_o` rises one clock edge after the launch edge. From then on each pixel costs one cycle for a set-color fill and two cycles otherwise. Final memory contents are due when `busy_o` has dropped. The bench drives inputs and samples every output at falling edges. It counts busy cycles, reads and writes, and records the first and last write address. These values are compared with exact figures derived from the size and the operation. Memory contents are checked only after `busy_o` has been seen low. For a zero-size or an ignored launch, the bench checks the write count and the affected memory before it issues the next stimulus.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;
  localparam int HALF_W  = 16;
  localparam int PIX_W   = 8;
  localparam logic CMD_FILL = 1'b0;
  localparam logic CMD_COPY = 1'b1;
  localparam logic ROP_SET  = 1'b0;
  localparam logic ROP_XOR  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } blit_state_e;
endpackage

// File: rtl/blit_walker.sv
`timescale 1ns/1ps
module blit_walker
  import blit_pkg::*;
#(
  parameter int AW       = 20,
  parameter int STRIDE_W = 16,
  parameter int COORD_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                x_back_i,
  input  logic                y_back_i,
  input  logic [COORD_W-1:0]  src_x_i,
  input  logic [COORD_W-1:0]  src_y_i,
  input  logic [COORD_W-1:0]  dst_x_i,
  input  logic [COORD_W-1:0]  dst_y_i,
  input  logic [HALF_W-1:0]   width_i,
  input  logic [HALF_W-1:0]   height_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [AW-1:0]       src_base_i,
  input  logic [AW-1:0]       dst_base_i,
  output logic [AW-1:0]       src_addr_o,
  output logic [AW-1:0]       dst_addr_o,
  output logic                last_o
);
  localparam int PW = HALF_W + 1;
  localparam int MW = PW + STRIDE_W;

  logic [HALF_W-1:0]   width_q, col_left_q, row_left_q;
  logic [STRIDE_W-1:0] stride_q;
  logic                x_back_q, y_back_q;
  logic                row_end;

  logic [COORD_W-1:0] x_in    [2];
  logic [COORD_W-1:0] y_in    [2];
  logic [AW-1:0]      base_in [2];
  logic [AW-1:0]      addr    [2];

  assign x_in[0] = src_x_i;  assign x_in[1] = dst_x_i;
  assign y_in[0] = src_y_i;  assign y_in[1] = dst_y_i;
  assign base_in[0] = src_base_i;
  assign base_in[1] = dst_base_i;

  assign row_end = (col_left_q == HALF_W'(1));
  assign last_o  = row_end && (row_left_q == HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q    <= '0;
      col_left_q <= '0;
      row_left_q <= '0;
      stride_q   <= '0;
      x_back_q   <= 1'b0;
      y_back_q   <= 1'b0;
    end else if (load_i) begin
      width_q    <= width_i;
      col_left_q <= width_i;
      row_left_q <= height_i;
      stride_q   <= stride_i;
      x_back_q   <= x_back_i;
      y_back_q   <= y_back_i;
    end else if (step_i) begin
      if (row_end) begin
        col_left_q <= width_q;
        row_left_q <= row_left_q - HALF_W'(1);
      end else begin
        col_left_q <= col_left_q - HALF_W'(1);
      end
    end
  end

  // channel 0 = source, channel 1 = destination
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [PW-1:0] x_start, y_start, x_q, x_row_q;
    logic [MW-1:0] row_off;
    logic [AW-1:0] row_q;

    assign x_start = x_back_i ? PW'(x_in[c]) + PW'(width_i) - PW'(1) : PW'(x_in[c]);
    assign y_start = y_back_i ? PW'(y_in[c]) + PW'(height_i) - PW'(1) : PW'(y_in[c]);
    assign row_off = MW'(y_start) * MW'(stride_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q     <= '0;
        x_row_q <= '0;
        row_q   <= '0;
      end else if (load_i) begin
        x_q     <= x_start;
        x_row_q <= x_start;
        row_q   <= base_in[c] + AW'(row_off);
      end else if (step_i) begin
        if (row_end) begin
          x_q   <= x_row_q;
          row_q <= y_back_q ? row_q - AW'(stride_q) : row_q + AW'(stride_q);
        end else begin
          x_q <= x_back_q ? x_q - PW'(1) : x_q + PW'(1);
        end
      end
    end

    assign addr[c] = row_q + AW'(x_q);
  end

  assign src_addr_o = addr[0];
  assign dst_addr_o = addr[1];
endmodule

// File: rtl/blit_fsm.sv
`timescale 1ns/1ps
module blit_fsm
  import blit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  logic        zero_i,
  input  logic        need_rd_i,
  input  logic        last_i,
  output logic        load_o,
  output blit_state_e state_o
);
  blit_state_e state_q, state_d;
  logic        need_rd_q;

  assign load_o  = (state_q == ST_IDLE) && launch_i && !zero_i;
  assign state_o = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_o) state_d = need_rd_i ? ST_READ : ST_WRITE;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (last_i)         state_d = ST_IDLE;
        else if (need_rd_q) state_d = ST_READ;
        else                state_d = ST_WRITE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      need_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) need_rd_q <= need_rd_i;
    end
  end
endmodule

// File: rtl/blit_rect_engine.sv
`timescale 1ns/1ps
module blit_rect_engine
  import blit_pkg::*;
#(
  parameter int AW       = 20,
  parameter int STRIDE_W = 16,
  parameter int COORD_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                cmd_i,
  input  logic                rop_i,
  input  logic [7:0]          color_i,
  input  logic [AW-1:0]       src_base_i,
  input  logic [AW-1:0]       dst_base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [31:0]         src_xy_i,
  input  logic [31:0]         dst_xy_i,
  input  logic [31:0]         size_i,
  output logic                busy_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic                mem_re_o,
  output logic                mem_we_o,
  output logic [7:0]          mem_wdata_o,
  input  logic [7:0]          mem_rdata_i
);
  logic [HALF_W-1:0]  width, height;
  logic [COORD_W-1:0] sx, sy, dx, dy;
  logic               zero, need_rd, x_back, y_back;
  logic               load, last;
  logic [AW-1:0]      src_addr, dst_addr;
  blit_state_e        state;
  logic               cmd_q, rop_q;
  logic [7:0]         color_q;

  assign width  = size_i[HALF_W-1:0];
  assign height = size_i[2*HALF_W-1:HALF_W];
  assign sx = src_xy_i[COORD_W-1:0];
  assign sy = src_xy_i[HALF_W+COORD_W-1:HALF_W];
  assign dx = dst_xy_i[COORD_W-1:0];
  assign dy = dst_xy_i[HALF_W+COORD_W-1:HALF_W];

  assign zero    = (width == '0) || (height == '0);
  assign need_rd = (cmd_i == CMD_COPY) || (rop_i == ROP_XOR);
  // copies walk away from the overlap on each axis; fills always walk forward
  assign x_back  = (cmd_i == CMD_COPY) && (sx <= dx);
  assign y_back  = (cmd_i == CMD_COPY) && (sy <= dy);

  blit_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch_i),
    .zero_i    (zero),
    .need_rd_i (need_rd),
    .last_i    (last),
    .load_o    (load),
    .state_o   (state)
  );

  blit_walker #(
    .AW       (AW),
    .STRIDE_W (STRIDE_W),
    .COORD_W  (COORD_W)
  ) u_walker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (state == ST_WRITE),
    .x_back_i   (x_back),
    .y_back_i   (y_back),
    .src_x_i    (sx),
    .src_y_i    (sy),
    .dst_x_i    (dx),
    .dst_y_i    (dy),
    .width_i    (width),
    .height_i   (height),
    .stride_i   (stride_i),
    .src_base_i (src_base_i),
    .dst_base_i (dst_base_i),
    .src_addr_o (src_addr),
    .dst_addr_o (dst_addr),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_FILL;
      rop_q   <= ROP_SET;
      color_q <= '0;
    end else if (load) begin
      cmd_q   <= cmd_i;
      rop_q   <= rop_i;
      color_q <= color_i;
    end
  end

  assign busy_o     = (state != ST_IDLE);
  assign mem_re_o   = (state == ST_READ);
  assign mem_we_o   = (state == ST_WRITE);
  assign mem_addr_o = (mem_re_o && cmd_q == CMD_COPY) ? src_addr : dst_addr;

  always_comb begin
    if (cmd_q == CMD_COPY)     mem_wdata_o = mem_rdata_i;
    else if (rop_q == ROP_XOR) mem_wdata_o = mem_rdata_i ^ color_q;
    else                       mem_wdata_o = color_q;
  end
endmodule

// File: rtl/blit_rect_checker.sv
`timescale 1ns/1ps
module blit_rect_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        launch_i,
  input logic [31:0] size_i,
  input logic        busy_o,
  input logic        mem_re_o,
  input logic        mem_we_o
);
  logic zero_sz;
  assign zero_sz = (size_i[15:0] == 16'd0) || (size_i[31:16] == 16'd0);

  assert_launch_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && launch_i && !zero_sz) |=> busy_o);

  assert_busy_ends_on_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o) |=> busy_o);

  assert_read_then_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o);

  assert_zero_size_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && launch_i && zero_sz) |=> !busy_o);

  assert_no_rw_clash_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_re_o || mem_we_o));
endmodule

bind blit_rect_engine blit_rect_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .launch_i (launch_i),
  .size_i   (size_i),
  .busy_o   (busy_o),
  .mem_re_o (mem_re_o),
  .mem_we_o (mem_we_o)
);

// File: tb/blit_rect_engine_bench.sv
`timescale 1ns/1ps
module blit_rect_engine_bench;
  localparam int AW = 14;
  localparam int MEM_N = 1 << AW;
  localparam int ST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          launch = 1'b0, cmd = 1'b0, rop = 1'b0;
  logic [7:0]    color = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [15:0]   stride = 16'(ST);
  logic [31:0]   src_xy = '0, dst_xy = '0, size = '0;
  logic          busy, re, we;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;

  blit_rect_engine #(.AW(AW)) u_blit_rect_engine (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .cmd_i(cmd), .rop_i(rop),
    .color_i(color), .src_base_i(src_base), .dst_base_i(dst_base),
    .stride_i(stride), .src_xy_i(src_xy), .dst_xy_i(dst_xy), .size_i(size),
    .busy_o(busy), .mem_addr_o(addr), .mem_re_o(re), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  logic [7:0] mem   [MEM_N];
  logic [7:0] exp_m [MEM_N];
  logic [7:0] tmp   [4096];
  logic       init_req = 1'b0;
  logic [7:0] seed = '0;

  function automatic logic [7:0] pat(int i, logic [7:0] s);
    return 8'(i * 13 + (i >> 6)) ^ s;
  endfunction

  always @(posedge clk) begin
    if (init_req) for (int i = 0; i < MEM_N; i++) mem[i] <= pat(i, seed);
    else if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  int n_wr, n_rd, n_busy, n_bad_if;
  int first_wr, last_wr;
  logic mon_clr = 1'b0;
  initial n_bad_if = 0;
  always @(negedge clk) begin
    if ((re && we) || (!busy && (re || we))) n_bad_if <= n_bad_if + 1;
    if (mon_clr) begin
      n_wr <= 0; n_rd <= 0; n_busy <= 0; first_wr <= -1; last_wr <= -1;
    end else begin
      if (we) begin
        if (n_wr == 0) first_wr <= int'(addr);
        last_wr <= int'(addr);
        n_wr <= n_wr + 1;
      end
      if (re) n_rd <= n_rd + 1;
      if (busy) n_busy <= n_busy + 1;
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic init_mem(logic [7:0] s);
    @(negedge clk); seed = s; init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    for (int i = 0; i < MEM_N; i++) exp_m[i] = pat(i, s);
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic start(logic c, logic r, logic [7:0] col, int sb, int db,
                       logic [31:0] sxy, logic [31:0] dxy, int w, int h);
    @(negedge clk);
    cmd = c; rop = r; color = col;
    src_base = AW'(sb); dst_base = AW'(db);
    src_xy = sxy; dst_xy = dxy; size = {16'(h), 16'(w)};
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) chk(1'b0, req, "watchdog busy", k, 0);
  endtask

  task automatic cmp_mem(string req);
    int mis = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== exp_m[i]) mis++;
    chk(mis == 0, req, "memory mismatches", mis, 0);
  endtask

  function automatic logic [31:0] xy(int x, int y);
    return {16'(y), 16'(x)};
  endfunction

  task automatic model_fill(int db, int x, int y, int w, int h, logic xr, logic [7:0] col);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int a = db + (y + r) * ST + x + c;
        exp_m[a] = xr ? (exp_m[a] ^ col) : col;
      end
  endtask

  task automatic model_copy(int sb, int sx, int sy, int db, int dx, int dy, int w, int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) tmp[r * w + c] = exp_m[sb + (sy + r) * ST + sx + c];
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) exp_m[db + (dy + r) * ST + dx + c] = tmp[r * w + c];
  endtask

  task automatic t_reset;
    chk(!busy && !re && !we, "R1", "reset idle outputs", int'({busy, re, we}), 0);
  endtask

  task automatic t_fill_set;
    init_mem(8'h11);
    start(1'b0, 1'b0, 8'hA5, 0, 256, 32'h0, xy(3, 2), 5, 3);
    wait_idle("R4");
    model_fill(256, 3, 2, 5, 3, 1'b0, 8'hA5);
    cmp_mem("R4");
    chk(n_rd == 0, "R4", "reads in set fill", n_rd, 0);
    chk(n_busy == 15, "R1", "busy cycles set fill", n_busy, 15);
    chk(first_wr == 256 + 2 * ST + 3, "R9", "first fill write", first_wr, 256 + 2 * ST + 3);
    chk(last_wr == 256 + 4 * ST + 7, "R3", "last fill write", last_wr, 256 + 4 * ST + 7);
  endtask

  task automatic t_fill_xor;
    init_mem(8'h3C);
    start(1'b0, 1'b1, 8'hFF, 0, 1024, 32'h0, xy(10, 4), 4, 4);
    wait_idle("R5");
    model_fill(1024, 10, 4, 4, 4, 1'b1, 8'hFF);
    cmp_mem("R5");
    chk(n_rd == 16 && n_wr == 16, "R5", "xor reads plus writes", n_rd + n_wr, 32);
    chk(n_busy == 32, "R1", "busy cycles xor fill", n_busy, 32);
  endtask

  task automatic t_copy_back;
    init_mem(8'h5A);
    start(1'b1, 1'b1, 8'h00, 4096, 4096, xy(10, 10), xy(12, 11), 6, 4);
    wait_idle("R8");
    model_copy(4096, 10, 10, 4096, 12, 11, 6, 4);
    cmp_mem("R6");
    chk(first_wr == 4096 + 14 * ST + 17, "R7", "first write backward copy",
        first_wr, 4096 + 14 * ST + 17);
    chk(n_busy == 48, "R1", "busy cycles copy", n_busy, 48);
  endtask

  task automatic t_copy_fwd;
    init_mem(8'h77);
    start(1'b1, 1'b0, 8'h00, 6000, 6000, xy(20, 20), xy(18, 19), 7, 5);
    wait_idle("R8");
    model_copy(6000, 20, 20, 6000, 18, 19, 7, 5);
    cmp_mem("R8");
    chk(first_wr == 6000 + 19 * ST + 18, "R8", "first write forward copy",
        first_wr, 6000 + 19 * ST + 18);
  endtask

  task automatic t_copy_mixed;
    init_mem(8'h99);
    start(1'b1, 1'b0, 8'h00, 9000, 9000, xy(5, 12), xy(8, 10), 6, 5);
    wait_idle("R7");
    model_copy(9000, 5, 12, 9000, 8, 10, 6, 5);
    cmp_mem("R7");
    chk(first_wr == 9000 + 10 * ST + 13, "R7", "first write mixed copy",
        first_wr, 9000 + 10 * ST + 13);
  endtask

  task automatic t_zero;
    init_mem(8'h21);
    start(1'b0, 1'b0, 8'hEE, 0, 512, 32'h0, xy(1, 1), 0, 3);
    chk(!busy, "R10", "busy after zero width", int'(busy), 0);
    start(1'b0, 1'b1, 8'hEE, 0, 512, 32'h0, xy(1, 1), 4, 0);
    repeat (4) @(negedge clk);
    chk(n_wr == 0 && n_busy == 0, "R10", "activity after zero size", n_wr + n_busy, 0);
    cmp_mem("R10");
  endtask

  task automatic t_busy_ignore;
    init_mem(8'h42);
    start(1'b0, 1'b0, 8'h11, 0, 512, 32'h0, xy(0, 0), 4, 4);
    repeat (3) @(negedge clk);
    color = 8'h22; dst_base = AW'(8000); launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    wait_idle("R11");
    model_fill(512, 0, 0, 4, 4, 1'b0, 8'h11);
    cmp_mem("R11");
    chk(n_wr == 16, "R11", "writes with launch while busy", n_wr, 16);
  endtask

  task automatic t_fold;
    init_mem(8'h0F);
    start(1'b0, 1'b0, 8'h5A, 0, 2000 + 5 * ST + 7, 32'hF000_F000, 32'hF000_F000, 3, 2);
    wait_idle("R2");
    model_fill(2000, 7, 5, 3, 2, 1'b0, 8'h5A);
    cmp_mem("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fill_set();
    t_fill_xor();
    t_copy_back();
    t_copy_fwd();
    t_copy_mixed();
    t_zero();
    t_busy_ignore();
    t_fold();
    chk(n_bad_if == 0, "R12", "port protocol violations", n_bad_if, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R1", "global watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule